// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 512K bytes (19 address bits, 8 data bits). Each single read or write arrives through a valid/ready handshake and is expanded into a sequence on the memory's active-low chip-select, write-strobe and read-enable pins. The data bus is split into an output value, an input value and a drive-enable, so that the pad ring builds the tri-state buffer.

Every phase length is a whole number of system clocks. The count is the ceiling of a nanosecond minimum divided by the clock period. A parameter picks one of three speed grades (55, 70 or 100 ns cycle). Writes are strobed by the write pin alone, and the read-enable pin stays high for the whole write. After every read the bus is left idle for at least the memory's release time before the controller may drive it again. Read data is returned with a one-cycle response pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, until the first request, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1.
- R2: A write accepted at a clock edge gives this sequence. For one cycle, chip-select is low with the write strobe high. Then the write strobe is low for WP_N cycles. Then chip-select stays low with the strobe high for one cycle. Then all pins are released and req_ready returns, WP_N+2 cycles after the accept edge.
- R3: Through a write, mem_oe_n stays 1. mem_dq_oe is 1 from the setup cycle through the hold cycle, with mem_dq_out equal to the request data and stable for at least the data setup time before the strobe rises. The write strobe and read-enable are never low together.
- R4: WP_N is the largest of ceil(tWP/T), ceil(tAW/T), ceil(tDW/T) and ceil(tWC/T)-2, where T is the clock period. For grade 0 (55 ns) the values are tWP=45, tAW=50, tDW=25 and tWC=55. At a 4 ns clock this gives WP_N=13.
- R5: A read accepted at a clock edge holds chip-select and read-enable low for RD_N = max(ceil(tRC/T), ceil(tOE/T)) cycles, with mem_dq_oe 0. For grade 0 the values are tRC=55 and tOE=30, which gives 14 cycles at 4 ns.
- R6: The read byte is sampled at the edge that ends the last access cycle. rsp_valid is 1 for exactly the following cycle, and rsp_rdata holds that byte until the next read completes.
- R7: After a read, chip-select and read-enable are high, and no request is accepted, for OHZ_N = ceil(tOHZ/T) cycles. For grade 0, tOHZ=20 ns, which gives 5 cycles. mem_dq_oe never rises before read-enable has been high for OHZ_N cycles.
- R8: mem_addr does not change while chip-select is low.
- R9: While req_ready is 0, a request held on req_valid is not taken. After the current operation, chip-select stays high and no response appears until a request is presented while ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken at the next edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
All outputs are registers loaded from the next state, so pins change at the accept edge. The bench counts sample points from that edge. At sample k it expects the pin pattern that R2 or R5 gives for cycle k. The response pulse is due at sample RD_N+1 and ready returns at sample WP_N+3 after a write or RD_N+OHZ_N+1 after a read. A memory model samples the pins between edges and measures every strobe width, data-stable window and bus-release gap in clock periods against the nanosecond minimums.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_RTRN
  } asram_st_e;

  function automatic int cdiv(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycle time (write and read), ns
  function automatic int t_cyc(input int grade);
    case (grade)
      1:       return 70;
      2:       return 100;
      default: return 55;
    endcase
  endfunction

  function automatic int t_strobe(input int grade);
    case (grade)
      1:       return 55;
      2:       return 70;
      default: return 45;
    endcase
  endfunction

  function automatic int t_addr_to_end(input int grade);
    case (grade)
      1:       return 60;
      2:       return 80;
      default: return 50;
    endcase
  endfunction

  function automatic int t_data_setup(input int grade);
    case (grade)
      1:       return 30;
      2:       return 40;
      default: return 25;
    endcase
  endfunction

  function automatic int t_rden_access(input int grade);
    case (grade)
      1:       return 35;
      2:       return 50;
      default: return 30;
    endcase
  endfunction

  function automatic int t_release(input int grade);
    case (grade)
      1:       return 25;
      2:       return 30;
      default: return 20;
    endcase
  endfunction

  // strobe-low cycles: setup and hold cycles surround it
  function automatic int wp_cycles(input int grade, input int clk_ns);
    int n;
    n = imax(cdiv(t_strobe(grade), clk_ns), cdiv(t_addr_to_end(grade), clk_ns));
    n = imax(n, cdiv(t_data_setup(grade), clk_ns));
    n = imax(n, cdiv(t_cyc(grade), clk_ns) - 2);
    return imax(n, 1);
  endfunction

  function automatic int rd_cycles(input int grade, input int clk_ns);
    return imax(imax(cdiv(t_cyc(grade), clk_ns), cdiv(t_rden_access(grade), clk_ns)), 1);
  endfunction

  function automatic int ohz_cycles(input int grade, input int clk_ns);
    return imax(cdiv(t_release(grade), clk_ns), 1);
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int WP_N  = 13,
  parameter int RD_N  = 14,
  parameter int OHZ_N = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  logic      req_write,
  output asram_st_e st_d,
  output logic      accept,
  output logic      rd_done
);
  localparam int MAXN  = (WP_N > RD_N) ? ((WP_N > OHZ_N) ? WP_N : OHZ_N)
                                       : ((RD_N > OHZ_N) ? RD_N : OHZ_N);
  localparam int CNT_W = $clog2(MAXN + 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_N - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_N - 1);
  localparam logic [CNT_W-1:0] OHZ_LD = CNT_W'(OHZ_N - 1);

  asram_st_e        st_q;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             zero;

  asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (zero)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_write) st_d = ST_WSET;
        else begin
          st_d   = ST_RACC;
          ld     = 1'b1;
          ld_val = RD_LD;
        end
      end
      ST_WSET: begin
        st_d   = ST_WPUL;
        ld     = 1'b1;
        ld_val = WP_LD;
      end
      ST_WPUL: if (zero) st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      ST_RACC: if (zero) begin
        st_d   = ST_RTRN;
        ld     = 1'b1;
        ld_val = OHZ_LD;
      end
      ST_RTRN: if (zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign rd_done = (st_q == ST_RACC) && zero;
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  asram_st_e         st_d,
  input  logic              accept,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic wr_phase;
  logic sel_phase;

  assign wr_phase  = (st_d == ST_WSET) || (st_d == ST_WPUL) || (st_d == ST_WHLD);
  assign sel_phase = wr_phase || (st_d == ST_RACC);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      req_ready <= (st_d == ST_IDLE);
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_dq_in;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !sel_phase;
      mem_we_n  <= (st_d != ST_WPUL);
      mem_oe_n  <= (st_d != ST_RACC);
      mem_dq_oe <= wr_phase;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int GRADE  = 0,
  parameter int CLK_NS = 4,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WP_N  = asram_pkg::wp_cycles(GRADE, CLK_NS);
  localparam int RD_N  = asram_pkg::rd_cycles(GRADE, CLK_NS);
  localparam int OHZ_N = asram_pkg::ohz_cycles(GRADE, CLK_NS);

  asram_pkg::asram_st_e st_d;
  logic accept;
  logic rd_done;

  asram_fsm #(.WP_N(WP_N), .RD_N(RD_N), .OHZ_N(OHZ_N)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .st_d      (st_d),
    .accept    (accept),
    .rd_done   (rd_done)
  );

  asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .st_d       (st_d),
    .accept     (accept),
    .rd_done    (rd_done),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int WP_N   = 13,
  parameter int RD_N   = 14,
  parameter int OHZ_N  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  logic [7:0] we_run;
  logic [7:0] oe_run;
  logic [7:0] oe_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_run <= '0;
      oe_gap <= 8'hff;
    end else begin
      we_run <= !mem_we_n ? ((we_run == 8'hff) ? we_run : we_run + 1'b1) : '0;
      oe_run <= !mem_oe_n ? ((oe_run == 8'hff) ? oe_run : oe_run + 1'b1) : '0;
      oe_gap <=  mem_oe_n ? ((oe_gap == 8'hff) ? oe_gap : oe_gap + 1'b1) : '0;
    end
  end

  assert_strobe_needs_select_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  assert_no_read_enable_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run >= 8'(WP_N)));

  assert_read_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_run >= 8'(RD_N)));

  assert_rsp_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_bus_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_gap >= 8'(OHZ_N)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .WP_N   (WP_N),
  .RD_N   (RD_N),
  .OHZ_N  (OHZ_N)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
  localparam int T = 4;
  // grade 0 minimums, ns
  localparam int B_TWC = 55, B_TWP = 45, B_TAW = 50, B_TDW = 25;
  localparam int B_TRC = 55, B_TOE = 30, B_TOHZ = 20;

  function automatic int cd(input int t);
    return (t + T - 1) / T;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WP  = 13;
  localparam int E_RD  = 14;
  localparam int E_OHZ = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #(T/2.0) clk = ~clk;

  asram_ctrl #(.GRADE(0), .CLK_NS(T)) u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // ---------------- memory model with timing monitor ----------------
  logic [7:0] mdl [1024];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[9:0]] : 8'h00;

  int we_low_run = 0, ce_low_run = 0, oe_low_run = 0, oe_high_run = 100, dq_run = 0;
  logic p_we = 1, p_oe = 1, p_ce = 1, p_dqoe = 0;
  logic [7:0]  p_dq = 0;
  logic [18:0] p_addr = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n && !p_ce && mem_addr != p_addr)
        chk(1'b0, "R8 address moved under select", int'(mem_addr), int'(p_addr));
      if (!mem_we_n && !mem_oe_n)
        chk(1'b0, "R3 strobe and read-enable both low", 0, 1);
      if (mem_we_n && !p_we) begin
        chk(we_low_run * T >= B_TWP && we_low_run * T >= B_TAW - T,
            "R4 strobe width ns", we_low_run * T, B_TWP);
        chk(ce_low_run * T >= B_TAW, "R4 select to end of write ns", ce_low_run * T, B_TAW);
        chk(dq_run * T >= B_TDW, "R3 data setup ns", dq_run * T, B_TDW);
        if (!mem_ce_n && mem_dq_oe) mdl[mem_addr[9:0]] = mem_dq_out;
      end
      if (mem_oe_n && !p_oe)
        chk(oe_low_run * T >= mx(B_TRC, B_TOE), "R5 read access ns", oe_low_run * T, B_TRC);
      if (mem_dq_oe && !p_dqoe)
        chk(oe_high_run * T >= B_TOHZ, "R7 bus release ns", oe_high_run * T, B_TOHZ);
      we_low_run  = !mem_we_n ? we_low_run + 1 : 0;
      ce_low_run  = !mem_ce_n ? ce_low_run + 1 : 0;
      oe_low_run  = !mem_oe_n ? oe_low_run + 1 : 0;
      oe_high_run =  mem_oe_n ? oe_high_run + 1 : 0;
      dq_run = !mem_dq_oe ? 0 : ((p_dqoe && mem_dq_out == p_dq) ? dq_run + 1 : 1);
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_ce = mem_ce_n;
    p_dqoe = mem_dq_oe; p_dq = mem_dq_out; p_addr = mem_addr;
  end

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5a;
  endfunction

  function automatic logic [4:0] pins();
    return {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready};
  endfunction

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit hold_busy);
    logic [4:0] e;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    for (int k = 1; k <= E_WP + 3; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (hold_busy) begin req_write = 0; req_addr = ~a; end
        else req_valid = 0;
      end
      if (k == E_WP + 1) req_valid = 0;
      if (k == 1 || k == E_WP + 2) e = 5'b01110;
      else if (k == E_WP + 3)      e = 5'b11101;
      else                         e = 5'b00110;
      chk(pins() == e, "R2 write pin pattern", int'(pins()), int'(e));
      if (k == 1) begin
        chk(mem_addr == a, "R2 write address", int'(mem_addr), int'(a));
        chk(mem_dq_out == d, "R3 write data", int'(mem_dq_out), int'(d));
      end
    end
    if (hold_busy)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(mem_ce_n && !rsp_valid, "R9 busy request not taken", int'({mem_ce_n, rsp_valid}), 2);
      end
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    logic [4:0] e;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    for (int k = 1; k <= E_RD + E_OHZ + 1; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 0;
      if (k <= E_RD)                 e = 5'b01000;
      else if (k <= E_RD + E_OHZ)    e = 5'b11100;
      else                           e = 5'b11101;
      chk(pins() == e, "R5/R7 read pin pattern", int'(pins()), int'(e));
      chk(rsp_valid == (k == E_RD + 1), "R6 response pulse", int'(rsp_valid), int'(k == E_RD + 1));
      if (k == E_RD + 1 || k == E_RD + E_OHZ + 1)
        chk(rsp_rdata == exp, "R6 read data", int'(rsp_rdata), int'(exp));
      if (k == 1) chk(mem_addr == a, "R8 read address", int'(mem_addr), int'(a));
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
    chk(mx(mx(cd(B_TWP), cd(B_TAW)), mx(cd(B_TDW), cd(B_TWC) - 2)) == E_WP, "R4 strobe count", E_WP, 13);
    chk(mx(cd(B_TRC), cd(B_TOE)) == E_RD && cd(B_TOHZ) == E_OHZ, "R5 read count", E_RD, 14);
    repeat (3) @(negedge clk);
    chk(pins() == 5'b11101 && !rsp_valid, "R1 reset state", int'(pins()), 5'b11101);
    @(negedge clk); rst = 0;
    repeat (3) @(negedge clk);
    chk(pins() == 5'b11101 && !rsp_valid, "R1 idle after reset", int'(pins()), 5'b11101);

    // walking ones, all-zero and all-one addresses: write then read each
    for (int i = 0; i < 21; i++) begin
      logic [18:0] a;
      a = (i < 19) ? 19'(1 << i) : ((i == 19) ? 19'h00000 : 19'h7ffff);
      do_write(a, pat(a), 1'b0);
      do_read(a, pat(a));
    end
    // block of distinct addresses written, then read back (read->read, read->write)
    for (int i = 0; i < 16; i++) begin
      logic [18:0] a;
      a = 19'(i * 67 + (i << 13));
      do_write(a, pat(a) ^ 8'(i), 1'b0);
    end
    for (int i = 0; i < 16; i++) begin
      logic [18:0] a;
      a = 19'(i * 67 + (i << 13));
      do_read(a, pat(a) ^ 8'(i));
    end
    // R9: request held while busy, then dropped
    do_write(19'h12345, 8'hc3, 1'b1);
    do_read(19'h12345, 8'hc3);
    finish_run();
  end
endmodule